// File: doc/BRIEF.md
# Framed Word Serializer with Alignment Insertion

This block converts a stream of parallel payload words into one serial line. Each word goes out as a 20-bit symbol: one leading marker bit at the high level, the payload bits in the order given, and one trailing marker bit at the low level. Because the trailing bit is low and the next leading bit is high, the line has a rising edge at every symbol boundary. A receiver can lock onto that edge without any line coding. Payload bits go out exactly as supplied, with no coding or scrambling.

The block runs on one fast clock and is paced by `bit_en`, a one-cycle strobe for each bit time. The clock multiplier that would produce the bit rate sits outside the block. The block counts 20 strobes per symbol, so the word rate is one twentieth of the bit rate.

On the first strobe of each symbol the block captures the parallel input and pulses `word_taken_o` so the source can advance. If `sync_req` is high at that strobe, the block sends a fixed alignment payload instead of the user word. In that payload the first half of the bits sent are ones and the second half are zeros. The path from capture to line output has the same register depth after every reset, so the latency is fixed.

Top module: `framed_word_serializer`

## Requirements
- R1: On the first enabled edge of a symbol, `ser_o` becomes 1 (leading marker) in the cycle after that edge.
- R2: On the 20th enabled edge of a symbol, `ser_o` becomes 0 (trailing marker), so each boundary shows a low-to-high step.
- R3: Payload bit i (bit 0 is the least significant) appears on `ser_o` after enabled edge i+2 of the symbol, unchanged from `din`.
- R4: If `sync_req` is 1 at the capture edge, the payload sent is bits 0..8 = 1 and bits 9..17 = 0 (0x001FF), whatever the value of `din`.
- R5: `ser_o` changes only in the cycle after an edge where `bit_en` is 1; it holds its value otherwise.
- R6: The capture edge is the first enabled edge after reset and every 20th enabled edge after that. `word_taken_o` is 1 for exactly the cycle after each capture edge and 0 otherwise.
- R7: While `rst` is high, and until the first enabled edge after it falls, `ser_o` is 0 and `word_taken_o` is 0. `bit_en` has no effect during reset.
- R8: Values of `din` and `sync_req` at non-capture edges do not affect the symbol being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe per bit time |
| din | input | PAYLOAD_W (18) | Parallel payload word |
| sync_req | input | 1 | Send the alignment payload instead of `din` |
| ser_o | output | 1 | Registered serial line |
| word_taken_o | output | 1 | Pulse: `din` was captured at the last edge |

## Verification
The bench builds the block with its default parameters: an 18-bit payload and a 9-ones alignment half, which gives the 20-bit symbol on which the leading and trailing marker positions depend. Across the run the strobe is driven on every cycle, on every third cycle and in random patterns. This exposes the hold behaviour between strobes and the stretching of a symbol over many clock cycles. `din` and `sync_req` are changed on every cycle, so a capture made at the wrong strobe shows up as a wrong payload bit. A reset in the middle of a symbol checks that symbol counting restarts from the first strobe afterwards.

// File: rtl/fws_pkg.sv
package fws_pkg;
  // line levels of the two framing markers
  localparam logic LEAD_LVL  = 1'b1;
  localparam logic TRAIL_LVL = 1'b0;
  // framing overhead in bit times
  localparam int unsigned MARKER_BITS = 2;
endpackage

// File: rtl/fws_frame_counter.sv
module fws_frame_counter #(
  parameter int unsigned FRAME_LEN = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  output logic at_first,
  output logic at_last
);
  localparam int unsigned CW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [CW-1:0] LAST_POS = CW'(FRAME_LEN - 1);

  logic [CW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (bit_en) begin
      if (pos_q == LAST_POS) pos_q <= '0;
      else                   pos_q <= pos_q + 1'b1;
    end
  end

  assign at_first = (pos_q == '0);
  assign at_last  = (pos_q == LAST_POS);

  // R6
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST_POS);

  // R5
  pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(pos_q));
endmodule

// File: rtl/fws_word_mux.sv
module fws_word_mux #(
  parameter int unsigned WIDTH = 18,
  parameter int unsigned ONES  = 9
) (
  input  logic [WIDTH-1:0] din,
  input  logic             sync_req,
  output logic [WIDTH-1:0] word
);
  logic [WIDTH-1:0] align_pat;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pat
    assign align_pat[i] = (i < ONES) ? 1'b1 : 1'b0;
  end

  always_comb begin
    word = sync_req ? align_pat : din;
  end
endmodule

// File: rtl/fws_shifter.sv
module fws_shifter #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             load,
  input  logic [WIDTH-1:0] word,
  output logic             ser_o,
  output logic             taken_o
);
  import fws_pkg::*;

  logic [WIDTH:0] shreg_q;
  logic           ser_q;
  logic           taken_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= {(WIDTH+1){TRAIL_LVL}};
      ser_q   <= TRAIL_LVL;
      taken_q <= 1'b0;
    end else begin
      taken_q <= bit_en && load;
      if (bit_en) begin
        if (load) begin
          ser_q   <= LEAD_LVL;
          shreg_q <= {TRAIL_LVL, word};
        end else begin
          ser_q   <= shreg_q[0];
          shreg_q <= {TRAIL_LVL, shreg_q[WIDTH:1]};
        end
      end
    end
  end

  assign ser_o   = ser_q;
  assign taken_o = taken_q;

  // R1
  lead_marker_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && load) |=> (ser_o == LEAD_LVL));

  // R6
  taken_single_chk: assert property (@(posedge clk) disable iff (rst)
    taken_o |=> !taken_o);
endmodule

// File: rtl/framed_word_serializer.sv
module framed_word_serializer #(
  parameter int unsigned PAYLOAD_W = 18,
  parameter int unsigned SYNC_ONES = PAYLOAD_W / 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_en,
  input  logic [PAYLOAD_W-1:0] din,
  input  logic                 sync_req,
  output logic                 ser_o,
  output logic                 word_taken_o
);
  import fws_pkg::*;

  localparam int unsigned FRAME_LEN = PAYLOAD_W + MARKER_BITS;

  logic                 at_first;
  logic                 at_last;
  logic [PAYLOAD_W-1:0] sel_word;

  fws_frame_counter #(.FRAME_LEN(FRAME_LEN)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .at_first (at_first),
    .at_last  (at_last)
  );

  fws_word_mux #(.WIDTH(PAYLOAD_W), .ONES(SYNC_ONES)) u_mux (
    .din      (din),
    .sync_req (sync_req),
    .word     (sel_word)
  );

  fws_shifter #(.WIDTH(PAYLOAD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .load    (at_first),
    .word    (sel_word),
    .ser_o   (ser_o),
    .taken_o (word_taken_o)
  );

  // R2
  trail_marker_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && at_last) |=> (ser_o == TRAIL_LVL));

  // R5
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(ser_o));

  // R7
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (ser_o == TRAIL_LVL && !word_taken_o));
endmodule

// File: tb/framed_word_serializer_test.sv
module framed_word_serializer_test;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 18;
  localparam int FL = PW + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bit_en = 1'b0;
  logic [PW-1:0] din = '0;
  logic          sync_req = 1'b0;
  logic          ser_o;
  logic          word_taken_o;

  int tests = 0;
  int fails = 0;

  logic [FL-1:0] exp_q[$];
  int   bitcnt = 0;
  logic pend_first = 1'b0;
  logic en_prev = 1'b0;
  logic first_prev = 1'b0;
  logic rst_prev = 1'b1;
  logic [FL-1:0] cur;
  int   mon_idx = 0;
  logic last_ser = 1'b0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  framed_word_serializer #(.PAYLOAD_W(PW)) uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .din(din),
    .sync_req(sync_req), .ser_o(ser_o), .word_taken_o(word_taken_o)
  );

  always @(posedge clk) begin
    en_prev    <= bit_en && !rst;
    first_prev <= pend_first;
    rst_prev   <= rst;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // monitor: pops expected symbols and compares the line bit by bit
  always @(negedge clk) begin
    if (rst_prev) begin
      check(ser_o == 1'b0, "R7", ser_o, 0);
      check(word_taken_o == 1'b0, "R7", word_taken_o, 0);
      exp_q.delete();
      mon_idx = 0;
      last_ser = ser_o;
    end else begin
      check(word_taken_o == (en_prev && first_prev), "R6", word_taken_o,
            int'(en_prev && first_prev));
      if (en_prev) begin
        if (first_prev) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R6", 0, 1);
            cur = '0;
          end else begin
            cur = exp_q.pop_front();
          end
          mon_idx = 0;
        end
        if (mon_idx == 0)
          check(ser_o == cur[0], "R1", ser_o, cur[0]);
        else if (mon_idx == FL-1)
          check(ser_o == cur[FL-1], "R2", ser_o, cur[FL-1]);
        else
          check(ser_o == cur[mon_idx], "R3,R4,R8", ser_o, cur[mon_idx]);
        mon_idx = (mon_idx == FL-1) ? 0 : mon_idx + 1;
      end else begin
        check(ser_o == last_ser, "R5", ser_o, last_ser);
      end
      last_ser = ser_o;
    end
  end

  // driver: one step per clock, pushes the expected symbol at each capture edge
  task automatic step(input logic en, input logic sreq);
    logic [FL-1:0] f;
    logic [PW-1:0] pl;
    @(negedge clk);
    din      = PW'($urandom);
    sync_req = sreq;
    bit_en   = en;
    pend_first = en && (bitcnt == 0);
    if (pend_first) begin
      for (int i = 0; i < PW; i++) pl[i] = sreq ? (i < PW/2) : din[i];
      f = '0;
      f[0] = 1'b1;
      for (int i = 0; i < PW; i++) f[i+1] = pl[i];
      f[FL-1] = 1'b0;
      exp_q.push_back(f);
    end
    if (en) bitcnt = (bitcnt == FL-1) ? 0 : bitcnt + 1;
  endtask

  task automatic step_rst(input logic en);
    @(negedge clk);
    rst = 1'b1;
    bit_en = en;
    din = PW'($urandom);
    pend_first = 1'b0;
    bitcnt = 0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) step_rst(1'b1);
    @(negedge clk);
    rst = 1'b0; bit_en = 1'b0; pend_first = 1'b0;
    // R7: idle before the first strobe
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    // R1 R2 R3: strobe every cycle
    for (int i = 0; i < 3*FL; i++) step(1'b1, 1'b0);
    // R5 R8: strobe every third cycle, sync_req toggling at random
    for (int i = 0; i < 12*FL; i++) step((i % 3) == 0, 1'($urandom));
    // R4: steady alignment request
    for (int i = 0; i < 2*FL; i++) step(1'b1, 1'b1);
    // R5: random strobe pattern
    for (int i = 0; i < 10*FL; i++) step(1'($urandom), 1'b0);
    // R7 R6: reset in mid symbol, strobes ignored
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step_rst(1'b1);
    @(negedge clk);
    rst = 1'b0; bit_en = 1'b0; pend_first = 1'b0;
    for (int i = 0; i < 2; i++) step(1'b0, 1'b0);
    for (int i = 0; i < 2*FL; i++) step(1'b1, (i % 7) == 3);
    while (bitcnt != 0) step(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule